// File: doc/BRIEF.md
# Event Timer Comparator Channel

One comparator channel of a high-precision event timer. The channel watches a shared free-running 64-bit main counter, driven in from outside, and sends a one-cycle interrupt pulse when the count reaches the value held in its comparator. It supports one-shot and periodic operation. It also has a narrow mode in which only the low 32 bits of the counter, comparator and period take part. In periodic mode the comparator moves forward by a programmed period after each match. In one-shot narrow mode the channel also signals when the low 32 bits of the counter roll over.

Software programs the channel through three write strobes that share one 32-bit data bus: a configuration write, a comparator low-half write and a comparator high-half write. Configuration, comparator and period are always visible on read-back outputs. The interrupt leaves on one line of a 32-line one-hot vector. The line is picked by a route field, or by fixed legacy routing for channels 0 and 1 when the legacy input is high.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the configuration reads 0x0000_0004_0000_0030: bit 4 = periodic capable, bit 5 = 64-bit capable, bit 34 = may route to line 2, all other bits 0. The comparator reads all ones, the period reads 0 and no interrupt line is active.
- R2: A configuration write changes only these low-word bits: bit 2 (channel enable), bit 3 (periodic), bit 6 (load-comparator flag), bit 8 (narrow mode) and bits 13:9 (route). All other bits keep their value, and the level-trigger bit 1 stays 0.
- R3: Writing the configuration with bit 8 set clears the high 32 bits of the comparator and of the period. While bit 8 is set, both high halves read 0.
- R4: When the count reaches or passes the comparator, a pulse shows on irq_o one cycle later. The count is taken at 64 bits, or at 32 bits in narrow mode. The comparator must have been ahead of the count in the cycle before. One crossing gives exactly one pulse.
- R5: A comparator write updates the comparator only in one-shot mode or when the load flag is set. In periodic mode a low-half write also stores the value as the period, and a high-half write without the load flag stores only the period high half. A write that leaves the comparator at or behind the count gives a pulse two cycles after the write strobe.
- R6: A value written to the period has its top bit cleared: bit 31 in narrow mode, bit 63 otherwise.
- R7: The load flag (bit 6) reads 0 after any comparator write, to either half.
- R8: In periodic mode with a nonzero period, a match adds the period to the comparator. The addition repeats once per cycle until the comparator is ahead of the count, and the whole catch-up gives only one pulse.
- R9: In narrow periodic mode the comparator sum wraps modulo 2^32.
- R10: In one-shot narrow mode a pulse is also sent when the low 32 bits of the count become smaller than in the previous cycle (a roll-over). In 64-bit mode a roll-over of the low bits sends no pulse.
- R11: The pulse goes to line number route (bits 13:9). When legacy_en_i is high, channel 0 uses line 0 and channel 1 uses line 8 instead.
- R12: No pulse is sent unless both glb_en_i and the channel enable bit 2 were high in the cycle of the match.
- R13: irq_o never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Shared main counter value |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_en_i | input | 1 | Legacy fixed routing select |
| cfg_wr_i | input | 1 | Configuration low-word write strobe |
| cmp_wr_lo_i | input | 1 | Comparator low-half write strobe |
| cmp_wr_hi_i | input | 1 | Comparator high-half write strobe |
| wdata_i | input | 32 | Write data for all strobes |
| cfg_o | output | 64 | Configuration read-back |
| cmp_o | output | 64 | Comparator read-back |
| period_o | output | 64 | Period read-back |
| irq_o | output | 32 | One-hot interrupt pulse vector |

## Verification
A write strobe seen at a clock edge shows on the read-back outputs right after that edge. A pulse caused by a count change is due one edge later. A pulse caused by a comparator write that is already behind the count is due two edges after the strobe, because the write first re-arms the channel. A catch-up in periodic mode adds one period per edge. The driver records the exact cycle each pulse is due and pushes it into a queue. The monitor samples on falling edges, compares each entry in its own cycle, and flags any pulse that no entry predicts.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int CNT_W    = 64;
    localparam int HALF_W   = 32;
    localparam int LINE_CNT = 32;
    localparam int RT_W     = $clog2(LINE_CNT);

    // configuration bit positions
    localparam int B_EN   = 2;
    localparam int B_PER  = 3;
    localparam int B_SETV = 6;
    localparam int B_M32  = 8;
    localparam int RT_LO  = 9;

    localparam logic [HALF_W-1:0] CFG_WMASK = 32'h0000_3F4C;
    localparam logic [CNT_W-1:0]  CFG_RST   = 64'h0000_0004_0000_0030;

    typedef struct packed {
        logic [CNT_W-1:0]    cfg;
        logic [CNT_W-1:0]    cmp;
        logic [CNT_W-1:0]    per;
        logic [HALF_W-1:0]   prev_lo;
        logic                armed;
        logic [LINE_CNT-1:0] irq;
    } chan_state_t;
endpackage

// File: rtl/evt_match.sv
module evt_match #(
    parameter int W = 64,
    parameter int H = 32
) (
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] cmp_i,
    input  logic [W-1:0] per_i,
    input  logic         narrow_i,
    output logic         behind_o,
    output logic [W-1:0] next_o
);
    logic [W-1:0] diff_w;
    logic [H-1:0] diff_h;
    logic [H-1:0] sum_h;

    always_comb begin
        diff_w = cmp_i - count_i;
        diff_h = cmp_i[H-1:0] - count_i[H-1:0];
        sum_h  = cmp_i[H-1:0] + per_i[H-1:0];
        if (narrow_i) begin
            behind_o = diff_h[H-1] || (diff_h == '0);
            next_o   = {{(W-H){1'b0}}, sum_h};
        end else begin
            behind_o = diff_w[W-1] || (diff_w == '0);
            next_o   = cmp_i + per_i;
        end
    end
endmodule

// File: rtl/evt_route.sv
module evt_route #(
    parameter int LINES    = 32,
    parameter int RW       = 5,
    parameter int CHAN_IDX = 0
) (
    input  logic             legacy_i,
    input  logic [RW-1:0]    route_i,
    output logic [LINES-1:0] vec_o
);
    localparam bit          HAS_LEG  = (CHAN_IDX < 2);
    localparam logic [RW-1:0] LEG_LINE = (CHAN_IDX == 0) ? RW'(0) : RW'(8);

    logic [RW-1:0] idx;
    assign idx = (HAS_LEG && legacy_i) ? LEG_LINE : route_i;

    for (genvar i = 0; i < LINES; i++) begin : g_dec
        assign vec_o[i] = (idx == RW'(i));
    end
endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
    import evt_pkg::*;
#(
    parameter int CHAN_IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    count_i,
    input  logic                glb_en_i,
    input  logic                legacy_en_i,
    input  logic                cfg_wr_i,
    input  logic                cmp_wr_lo_i,
    input  logic                cmp_wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output logic [CNT_W-1:0]    cfg_o,
    output logic [CNT_W-1:0]    cmp_o,
    output logic [CNT_W-1:0]    period_o,
    output logic [LINE_CNT-1:0] irq_o
);
    chan_state_t s_d, s_q;

    logic                narrow, periodic, setv;
    logic                behind;
    logic [CNT_W-1:0]    next_cmp;
    logic [LINE_CNT-1:0] line_vec;
    logic                rollover, fire;
    logic [HALF_W-1:0]   per_lo_val, per_hi_val;

    assign narrow   = s_q.cfg[B_M32];
    assign periodic = s_q.cfg[B_PER];
    assign setv     = s_q.cfg[B_SETV];

    evt_match #(.W(CNT_W), .H(HALF_W)) u_match (
        .count_i  (count_i),
        .cmp_i    (s_q.cmp),
        .per_i    (s_q.per),
        .narrow_i (narrow),
        .behind_o (behind),
        .next_o   (next_cmp)
    );

    evt_route #(.LINES(LINE_CNT), .RW(RT_W), .CHAN_IDX(CHAN_IDX)) u_route (
        .legacy_i (legacy_en_i),
        .route_i  (s_q.cfg[RT_LO +: RT_W]),
        .vec_o    (line_vec)
    );

    always_comb begin
        s_d = s_q;

        rollover = narrow && !periodic && (count_i[HALF_W-1:0] < s_q.prev_lo);
        fire     = (s_q.armed && behind) || rollover;

        per_lo_val = narrow ? {1'b0, wdata_i[HALF_W-2:0]} : wdata_i;
        per_hi_val = narrow ? '0 : {1'b0, wdata_i[HALF_W-2:0]};

        s_d.prev_lo = count_i[HALF_W-1:0];
        s_d.armed   = !behind;
        s_d.irq     = (fire && glb_en_i && s_q.cfg[B_EN]) ? line_vec : '0;

        if (behind && periodic && (s_q.per != '0)) begin
            s_d.cmp = next_cmp;
        end

        if (cfg_wr_i) begin
            s_d.cfg[HALF_W-1:0] = (wdata_i & CFG_WMASK) | (s_q.cfg[HALF_W-1:0] & ~CFG_WMASK);
            if (wdata_i[B_M32]) begin
                s_d.cmp[CNT_W-1:HALF_W] = '0;
                s_d.per[CNT_W-1:HALF_W] = '0;
            end
        end

        if (cmp_wr_lo_i) begin
            if (!periodic || setv) begin
                s_d.cmp[HALF_W-1:0] = wdata_i;
            end
            if (periodic) begin
                s_d.per[HALF_W-1:0] = per_lo_val;
            end
            s_d.cfg[B_SETV] = 1'b0;
            s_d.armed       = 1'b1;
        end

        if (cmp_wr_hi_i) begin
            if (!periodic || setv) begin
                s_d.cmp[CNT_W-1:HALF_W] = narrow ? '0 : wdata_i;
            end else begin
                s_d.per[CNT_W-1:HALF_W] = per_hi_val;
            end
            s_d.cfg[B_SETV] = 1'b0;
            s_d.armed       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cfg     <= CFG_RST;
            s_q.cmp     <= '1;
            s_q.per     <= '0;
            s_q.prev_lo <= '0;
            s_q.armed   <= 1'b0;
            s_q.irq     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o    = s_q.cfg;
    assign cmp_o    = s_q.cmp;
    assign period_o = s_q.per;
    assign irq_o    = s_q.irq;
endmodule

// File: rtl/evt_cmp_checker.sv
module evt_cmp_checker #(
    parameter int CHAN_IDX = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        glb_en_i,
    input logic        legacy_en_i,
    input logic        cmp_wr_lo_i,
    input logic        cmp_wr_hi_i,
    input logic [63:0] cfg_o,
    input logic [63:0] cmp_o,
    input logic [63:0] period_o,
    input logic [31:0] irq_o
);
    localparam logic [31:0] LEG_VEC = (CHAN_IDX == 0) ? 32'h0000_0001 : 32'h0000_0100;

    a_r13_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    a_r12_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_i || !cfg_o[2]) |=> (irq_o == '0));

    a_r7_setval_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_lo_i || cmp_wr_hi_i) |=> !cfg_o[6]);

    a_r3_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[8] |-> ((cmp_o[63:32] == '0) && (period_o[63:32] == '0)));

    a_r6_period_top: assert property (@(posedge clk) disable iff (!rst_n)
        !period_o[63]);

    a_r1_caps_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_o[5:4] == 2'b11) && cfg_o[34] && !cfg_o[1]);

    a_r11_legacy_line: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_en_i && (CHAN_IDX < 2)) |=> ((irq_o & ~LEG_VEC) == '0));
endmodule

bind evt_cmp_channel evt_cmp_checker #(.CHAN_IDX(CHAN_IDX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en_i    (glb_en_i),
    .legacy_en_i (legacy_en_i),
    .cmp_wr_lo_i (cmp_wr_lo_i),
    .cmp_wr_hi_i (cmp_wr_hi_i),
    .cfg_o       (cfg_o),
    .cmp_o       (cmp_o),
    .period_o    (period_o),
    .irq_o       (irq_o)
);

// File: tb/evt_cmp_channel_test.sv
`timescale 1ns/1ps
module evt_cmp_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        glb_en = 1'b0, legacy_en = 1'b0;
    logic        cfg_wr = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
    logic [31:0] wdata = '0;
    logic [63:0] cfg_o, cmp_o, period_o, cfg_b, cmp_b, per_b;
    logic [31:0] irq_o, irq_b;

    int checks = 0, errors = 0, cyc = 0;
    bit run = 1'b0, done = 1'b0;

    typedef struct { int cyc; logic [31:0] val; string tag; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    evt_cmp_channel #(.CHAN_IDX(0)) uut (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(glb_en), .legacy_en_i(legacy_en),
        .cfg_wr_i(cfg_wr), .cmp_wr_lo_i(wr_lo), .cmp_wr_hi_i(wr_hi), .wdata_i(wdata),
        .cfg_o(cfg_o), .cmp_o(cmp_o), .period_o(period_o), .irq_o(irq_o));

    evt_cmp_channel #(.CHAN_IDX(1)) uut_b (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(glb_en), .legacy_en_i(legacy_en),
        .cfg_wr_i(cfg_wr), .cmp_wr_lo_i(wr_lo), .cmp_wr_hi_i(wr_hi), .wdata_i(wdata),
        .cfg_o(cfg_b), .cmp_o(cmp_b), .period_o(per_b), .irq_o(irq_b));

    // monitor: scoreboard of expected pulses, any unpredicted pulse is an error (R13)
    always @(negedge clk) begin
        if (run) begin
            if (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (e.cyc != cyc || irq_o !== e.val) begin
                    errors++;
                    $display("FAIL %s irq actual=%h expected=%h (cycle %0d due %0d)",
                             e.tag, irq_o, e.val, cyc, e.cyc);
                end
            end else if (irq_o !== '0) begin
                checks++;
                errors++;
                $display("FAIL R13 unexpected pulse actual=%h expected=00000000", irq_o);
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int off, logic [31:0] v, string tag);
        exp_t e;
        e.cyc = cyc + off; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic setcnt(logic [63:0] v);
        @(negedge clk); cnt = v;
    endtask

    task automatic setcnt_exp(logic [63:0] v, logic [31:0] iv, string tag);
        @(negedge clk); cnt = v; push(1, iv, tag);
    endtask

    task automatic wr_cfg(logic [31:0] v);
        @(negedge clk); cfg_wr = 1'b1; wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic wr_cmp(bit hi, logic [31:0] v, bit exp_fire, logic [31:0] iv, string tag);
        @(negedge clk);
        if (hi) wr_hi = 1'b1; else wr_lo = 1'b1;
        wdata = v;
        if (exp_fire) push(2, iv, tag);
        @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        run = 1'b1;
        // R1 reset state
        chk("R1 cfg", cfg_o, 64'h0000_0004_0000_0030);
        chk("R1 cmp", cmp_o, '1);
        chk("R1 period", period_o, '0);
        chk("R1 irq", {32'h0, irq_o}, '0);

        // R2 / R3: write all ones, only writable bits change, narrow mode truncates
        wr_cfg(32'hFFFF_FFFF);
        chk("R2 cfg all ones", cfg_o, 64'h0000_0004_0000_3F7C);
        chk("R3 cmp truncated", cmp_o, 64'h0000_0000_FFFF_FFFF);
        wr_cfg(32'h0);
        chk("R2 cfg cleared", cfg_o, 64'h0000_0004_0000_0030);

        // R4 / R11: one-shot match on route line 5
        glb_en = 1'b1;
        wr_cfg(32'h0000_0A04);
        wr_cmp(1'b0, 32'd100, 1'b0, '0, "");
        chk("R5 one-shot cmp", cmp_o, 64'd100);
        setcnt(64'd99);
        tick(1);
        setcnt_exp(64'd100, 32'h20, "R4 match R11 route");
        setcnt(64'd101);
        tick(2);

        // R5: comparator written behind the count fires two cycles after the strobe
        setcnt(64'd200);
        wr_cmp(1'b0, 32'd150, 1'b1, 32'h20, "R5 write behind");
        tick(2);

        // R12: global enable low, then channel enable low
        glb_en = 1'b0;
        wr_cmp(1'b0, 32'd300, 1'b0, '0, "");
        setcnt_exp(64'd300, 32'h0, "R12 global off");
        tick(1);
        glb_en = 1'b1;
        wr_cfg(32'h0000_0A00);
        wr_cmp(1'b0, 32'd400, 1'b0, '0, "");
        setcnt_exp(64'd400, 32'h0, "R12 channel off");
        tick(1);

        // R5 / R7 / R8: periodic with load flag
        setcnt(64'd1000);
        wr_cfg(32'h0000_0A4C);
        chk("R2 load flag set", cfg_o, 64'h0000_0004_0000_0A7C);
        wr_cmp(1'b0, 32'd1010, 1'b0, '0, "");
        chk("R7 load flag cleared", {63'h0, cfg_o[6]}, 64'h0);
        chk("R5 cmp with flag", cmp_o, 64'd1010);
        chk("R5 period with flag", period_o, 64'd1010);
        wr_cmp(1'b0, 32'd50, 1'b0, '0, "");
        chk("R5 cmp kept", cmp_o, 64'd1010);
        chk("R5 period only", period_o, 64'd50);
        setcnt_exp(64'd1010, 32'h20, "R8 periodic match");
        tick(1);
        chk("R8 reload", cmp_o, 64'd1060);
        tick(1);
        setcnt_exp(64'd1200, 32'h20, "R8 catch-up single pulse");
        tick(3);
        chk("R8 catch-up result", cmp_o, 64'd1210);

        // R6 64-bit period mask
        wr_cmp(1'b1, 32'hFFFF_FFFF, 1'b0, '0, "");
        chk("R6 period bit63", period_o, 64'h7FFF_FFFF_0000_0032);
        wr_cmp(1'b1, 32'h0, 1'b0, '0, "");
        chk("R6 period restore", period_o, 64'd50);

        // R9 / R6 narrow periodic
        wr_cfg(32'h0000_0B4C);
        chk("R3 narrow cmp", cmp_o, 64'd1210);
        wr_cmp(1'b0, 32'h0000_5000, 1'b0, '0, "");
        setcnt(64'hFFFF_FF00);
        wr_cfg(32'h0000_0B4C);
        wr_cmp(1'b0, 32'hFFFF_FFC0, 1'b0, '0, "");
        chk("R6 narrow period bit31", period_o, 64'h7FFF_FFC0);
        chk("R5 narrow cmp", cmp_o, 64'hFFFF_FFC0);
        wr_cmp(1'b0, 32'h0000_0100, 1'b0, '0, "");
        setcnt_exp(64'hFFFF_FFC0, 32'h20, "R8 narrow match");
        tick(1);
        chk("R9 modular sum", cmp_o, 64'h0000_00C0);

        // R10 one-shot narrow roll-over
        wr_cfg(32'h0000_0B04);
        setcnt(64'hFFFF_FFF0);
        tick(1);
        setcnt_exp(64'h1_0000_0005, 32'h20, "R10 roll-over pulse");
        setcnt_exp(64'h1_0000_00C0, 32'h20, "R4 narrow match");
        tick(1);
        wr_cfg(32'h0000_0A04);
        setcnt(64'h1_FFFF_FFF8);
        tick(1);
        setcnt_exp(64'h2_0000_0004, 32'h0, "R10 no roll-over pulse in 64-bit");
        tick(1);

        // R11 legacy routing for channels 0 and 1
        wr_cmp(1'b1, 32'd3, 1'b0, '0, "");
        wr_cmp(1'b0, 32'h10, 1'b0, '0, "");
        chk("R5 64-bit cmp halves", cmp_o, 64'h3_0000_0010);
        legacy_en = 1'b1;
        setcnt_exp(64'h3_0000_0010, 32'h1, "R11 legacy channel 0");
        tick(1);
        chk("R11 legacy channel 1", {32'h0, irq_b}, 64'h100);
        tick(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule